// File: doc/BRIEF.md
# Lane-Grouped Compare Result Merger

This block takes per-lane compare flags for a SIMD datapath and turns them into one compare result for each group of lanes. Each lane holds a fixed-width slice of two operands. Comparators outside this block produce two flags per lane: one says the slices are equal and one says the A slice is above the B slice. A run-time gate vector splits the lanes into groups. Each group is treated as one wider operand, and its highest lane is the most significant.

Two control bits pick the operation. The seed bit starts the running result at the bottom of each group. The greater-than enable bit lets a lane's greater-than flag set that running result. Together they give equality, greater-than, or greater-or-equal from a single chain of logic. The result of a group appears only on the group's highest lane, and every other output bit reads 0.

The block is purely combinational. It has no clock and no reset, and its outputs follow its inputs within the same evaluation.

Top module: `grp_cmp_merge`

## Requirements
- R1: With seed_in=0 and gt_enable=1, the result of each group is 1 exactly when the group's concatenated A value is greater than its concatenated B value. The highest lane of the group is the most significant.
- R2: With seed_in=1 and gt_enable=0, the result of each group is the AND of the eq_flags bits of its lanes.
- R3: With seed_in=1 and gt_enable=1, the result of each group is 1 exactly when the group's concatenated A value is greater than or equal to its concatenated B value.
- R4: lane_gates bit i set to 1 splits lane i from lane i+1 into different groups. Bit i set to 0 puts them in the same group.
- R5: Each group's result is driven on results bit (highest lane of the group). Every other bit of a group with two or more lanes is 0, so the number of 1 bits in results is at most the number of groups.
- R6: With seed_in=0 and gt_enable=0, every results bit is 0.
- R7: With every lane_gates bit at 0, results bit LANES-1 gives the selected comparison of the full-width operands, and all lower bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| eq_flags | input | LANES | Per-lane flag: the A slice equals the B slice |
| gt_flags | input | LANES | Per-lane flag: the A slice is greater than the B slice |
| lane_gates | input | LANES-1 | Bit i set to 1 cuts the grouping between lane i and lane i+1 |
| seed_in | input | 1 | Value the running result starts from at the bottom of each group |
| gt_enable | input | 1 | Lets a lane's greater-than flag set the running result |
| results | output | LANES | One compare result per group, placed on the group's highest lane |

## Verification
The assertions check, on every input change, the following properties:
- the all-zero output when both control bits are low;
- the limit on how many result bits can be set, given the gate pattern;
- full-width equality when no gate is set;
- that a lane standing alone in greater-than mode reports its own flag.

The bench's scenarios are needed for behaviour that depends on the flag values across a group: whether lower lanes are correctly ignored once a higher lane differs, and whether greater-or-equal is correct across merged groups. The bench checks these against a model that compares whole concatenated groups.

// File: rtl/grp_cmp_pkg.sv
package grp_cmp_pkg;
  // One step of the running compare: a greater-than flag (when enabled)
  // sets the result, and an equal flag passes the lower result through.
  function automatic logic chain_step(input logic gt_en, input logic gt_l,
                                      input logic eq_l, input logic below);
    return (gt_en & gt_l) | (eq_l & below);
  endfunction
endpackage

// File: rtl/grp_cmp_lane.sv
module grp_cmp_lane
  import grp_cmp_pkg::*;
(
  input  logic eq_l,
  input  logic gt_l,
  input  logic gt_en,
  input  logic seed,
  input  logic grp_start,
  input  logic carry_in,
  output logic carry_out
);
  logic below;

  always_comb begin
    below     = grp_start ? seed : carry_in;
    carry_out = chain_step(gt_en, gt_l, eq_l, below);
  end
endmodule

// File: rtl/grp_cmp_place.sv
module grp_cmp_place #(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0] chain,
  input  logic [LANES-2:0] gates,
  output logic [LANES-1:0] results
);
  localparam int TOP = LANES - 1;

  // A lane drives its running value only if it is the highest lane of its group.
  for (genvar i = 0; i < TOP; i++) begin : g_mid
    assign results[i] = chain[i] & gates[i];
  end
  assign results[TOP] = chain[TOP];
endmodule

// File: rtl/grp_cmp_merge.sv
module grp_cmp_merge #(
  parameter int LANES = 3
) (
  input  logic [LANES-1:0] eq_flags,
  input  logic [LANES-1:0] gt_flags,
  input  logic [LANES-2:0] lane_gates,
  input  logic             seed_in,
  input  logic             gt_enable,
  output logic [LANES-1:0] results
);
  localparam int TOP = LANES - 1;

  logic [LANES-1:0] chain;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic start_w, cin_w;
    if (i == 0) begin : g_first
      assign start_w = 1'b1;
      assign cin_w   = seed_in;
    end else begin : g_rest
      assign start_w = lane_gates[i-1];
      assign cin_w   = chain[i-1];
    end

    grp_cmp_lane u_lane (
      .eq_l      (eq_flags[i]),
      .gt_l      (gt_flags[i]),
      .gt_en     (gt_enable),
      .seed      (seed_in),
      .grp_start (start_w),
      .carry_in  (cin_w),
      .carry_out (chain[i])
    );

    // A lane whose group has only itself reports its own greater-than flag (R1).
    logic hi_cut;
    if (i == TOP) begin : g_hi_top
      assign hi_cut = 1'b1;
    end else begin : g_hi_mid
      assign hi_cut = lane_gates[i];
    end
    always_comb begin
      if (start_w && hi_cut && !seed_in && gt_enable)
        assert_lane_alone_R1: assert (results[i] == gt_flags[i])
          else $error("lone lane %0d result mismatch", i);
    end
  end

  grp_cmp_place #(.LANES(LANES)) u_place (
    .chain   (chain),
    .gates   (lane_gates),
    .results (results)
  );

  // Checks that tie the output to the inputs over all lanes.
  always_comb begin
    if (!seed_in && !gt_enable)
      assert_idle_zero_R6: assert (results == '0)
        else $error("results not zero with both controls low");
    assert_group_count_R5: assert ($countones(results) <= $countones(lane_gates) + 1)
      else $error("more result bits than groups");
    if (seed_in && !gt_enable && lane_gates == '0)
      assert_full_eq_R7: assert (results == {(&eq_flags), {TOP{1'b0}}})
        else $error("full-width equality mismatch");
  end
endmodule

// File: tb/grp_cmp_merge_tb.sv
module grp_cmp_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 3;
  localparam int SEG = 8;
  localparam int WD = LANES * SEG;
  localparam int WATCHDOG = 20000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [LANES-1:0] eq_flags, gt_flags, results;
  logic [LANES-2:0] lane_gates;
  logic seed_in, gt_enable;
  logic [WD-1:0] op_a, op_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  grp_cmp_merge #(.LANES(LANES)) u_dut (
    .eq_flags(eq_flags), .gt_flags(gt_flags), .lane_gates(lane_gates),
    .seed_in(seed_in), .gt_enable(gt_enable), .results(results)
  );

  // Per-lane flags from the operand slices (lane 0 is bits 7:0).
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      eq_flags[i] = op_a[i*SEG +: SEG] == op_b[i*SEG +: SEG];
      gt_flags[i] = op_a[i*SEG +: SEG] >  op_b[i*SEG +: SEG];
    end
  end

  // Model: compare whole concatenated groups and place the result on the top lane.
  function automatic logic [LANES-1:0] model(input logic [WD-1:0] a, input logic [WD-1:0] b,
                                             input logic [LANES-2:0] g, input logic s, input logic e);
    logic [LANES-1:0] r = '0;
    int lo = 0;
    for (int i = 0; i < LANES; i++) begin
      if (i == LANES-1 || g[i]) begin
        logic [WD-1:0] ga = '0, gb = '0;
        for (int k = i; k >= lo; k--) begin
          ga = (ga << SEG) | WD'(a[k*SEG +: SEG]);
          gb = (gb << SEG) | WD'(b[k*SEG +: SEG]);
        end
        case ({s, e})
          2'b01: r[i] = ga > gb;
          2'b10: r[i] = ga == gb;
          2'b11: r[i] = ga >= gb;
          default: r[i] = 1'b0;
        endcase
        lo = i + 1;
      end
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [LANES-1:0] exp);
    checks++;
    if (results !== exp) begin
      failures++;
      $display("FAIL %s: results=%b expected=%b (gates=%b seed=%b gten=%b)",
               req, results, exp, lane_gates, seed_in, gt_enable);
    end
  endtask

  task automatic apply(input logic [WD-1:0] a, input logic [WD-1:0] b,
                       input logic [LANES-2:0] g, input logic s, input logic e);
    @(posedge clk);
    op_a = a; op_b = b; lane_gates = g; seed_in = s; gt_enable = e;
    @(negedge clk);
  endtask

  function automatic string mode_tag(input logic s, input logic e);
    case ({s, e})
      2'b01: return "R1";
      2'b10: return "R2";
      2'b11: return "R3";
      default: return "R6";
    endcase
  endfunction

  // Table entry layout: a[54:31], b[30:7], gates[6:5], seed[4], gten[3], expected[2:0]
  localparam int NV = 11;
  localparam logic [54:0] TBL [NV] = '{
    {24'h010203, 24'h010203, 2'b00, 1'b1, 1'b0, 3'b100}, // R2 R7 full eq
    {24'h010203, 24'h010203, 2'b00, 1'b0, 1'b1, 3'b000}, // R1 equal is not greater
    {24'h010203, 24'h010203, 2'b00, 1'b1, 1'b1, 3'b100}, // R3 equal is ge
    {24'h020000, 24'h01FFFF, 2'b00, 1'b0, 1'b1, 3'b100}, // R1 R7 top lane decides
    {24'h020000, 24'h01FFFF, 2'b11, 1'b0, 1'b1, 3'b100}, // R4 split lanes
    {24'h0000FF, 24'h000001, 2'b11, 1'b0, 1'b1, 3'b001}, // R1 lone low lane
    {24'h0000FF, 24'h000001, 2'b01, 1'b0, 1'b1, 3'b001}, // R4 R5 lanes 1,2 merged
    {24'h0000FF, 24'h000001, 2'b01, 1'b1, 1'b1, 3'b101}, // R3 ge in two groups
    {24'h000500, 24'h000400, 2'b10, 1'b0, 1'b1, 3'b010}, // R5 result on lane 1
    {24'h000500, 24'h000400, 2'b10, 1'b1, 1'b0, 3'b100}, // R2 merged group unequal
    {24'h0000FF, 24'h000001, 2'b11, 1'b0, 1'b0, 3'b000}  // R6 both controls low
  };

  initial begin
    op_a = '0; op_b = '0; lane_gates = '0; seed_in = 1'b0; gt_enable = 1'b0;
    @(negedge clk);
    check("R6 idle inputs", '0);

    for (int v = 0; v < NV; v++) begin
      logic [54:0] t = TBL[v];
      apply(t[54:31], t[30:7], t[6:5], t[4], t[3]);
      check($sformatf("%s table entry %0d", mode_tag(t[4], t[3]), v), t[2:0]);
    end

    // R7: all gates clear, each mode against the full-width comparison.
    for (int m = 1; m < 4; m++) begin
      logic [WD-1:0] ra = WD'($urandom), rb;
      rb = (m == 2) ? ra : WD'($urandom);
      apply(ra, rb, '0, m[1], m[0]);
      check("R7 full width", model(ra, rb, '0, m[1], m[0]));
    end

    // Random slices and gates; half the slices copied to force equal lanes.
    for (int n = 0; n < 600; n++) begin
      logic [WD-1:0] ra = WD'($urandom), rb = WD'($urandom);
      logic [LANES-2:0] rg = (LANES-1)'($urandom);
      logic [1:0] md = 2'($urandom);
      for (int i = 0; i < LANES; i++)
        if ($urandom % 2) rb[i*SEG +: SEG] = ra[i*SEG +: SEG];
      apply(ra, rb, rg, md[1], md[0]);
      check(mode_tag(md[1], md[0]), model(ra, rb, rg, md[1], md[0]));
      // R5: lanes below a closed gate stay 0.
      for (int i = 0; i < LANES-1; i++)
        if (!rg[i]) begin
          checks++;
          if (results[i] !== 1'b0) begin
            failures++;
            $display("FAIL R5: results[%0d]=%b expected=0", i, results[i]);
          end
        end
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule